// File: doc/BRIEF.md
# Load/Store and Branch Address Generator

This block sits in the front of an execution pipeline. Each cycle it can accept one 32-bit instruction word together with the operand values already read for it: the base register, the register tested by a conditional branch, and the address of the instruction itself. From the 6-bit opcode in bits [31:26] it sorts the instruction into a memory access or a PC-relative branch. It then produces a 64-bit virtual address that is registered and appears one cycle later.

A memory access adds the base register to its 16-bit signed offset from bits [15:0]. A branch takes its 21-bit offset from bits [20:0] and counts it in 4-byte words. The offset is sign-extended and added to the address of the following instruction. Conditional branches also report whether they are taken, based on the sign or zero state of the tested register. The aligned-by-force quadword load rounds its address down to an 8-byte boundary. Plain quadword accesses that land off an 8-byte boundary are flagged. Byte order is little-endian and addresses are the full 64 bits, so no part of the address is truncated.

Opcode encodings (hex): 64-bit load 0x29, 64-bit aligned-by-force load 0x0B, 64-bit store 0x2D, 32-bit load 0x28, 32-bit store 0x2C, unconditional branch 0x30, branch-if-zero 0x39, branch-if-nonzero 0x3D, branch-if-negative 0x3A, branch-if-non-negative 0x3E. Every other opcode is unrecognized.

Top module: `addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are cleared to zero on that edge.
- R2: For a recognized memory opcode other than 0x0B, `addr` equals `rb_val` plus instr[15:0] sign-extended to 64 bits. `ra_sel` equals instr[25:21]. Both appear on the clock edge after the instruction is presented with `in_valid` high.
- R3: For a branch opcode, `addr` equals `pc + 4` plus instr[20:0] shifted left by two and sign-extended to 64 bits, with two's-complement wrap at 64 bits.
- R4: For opcode 0x0B, `addr` is the R2 sum with bits [2:0] forced to zero.
- R5: Conditional branches are taken when `ra_val` matches their test: 0x39 when zero, 0x3D when nonzero, 0x3A when bit 63 is set, 0x3E when bit 63 is clear.
- R6: Opcode 0x30 is always taken. `taken` is zero for every memory opcode.
- R7: `misaligned` is set only for 0x29 and 0x2D whose address has nonzero bits [2:0]. It is never set for 0x0B, for 32-bit accesses or for branches.
- R8: When `in_valid` is low or the opcode is unrecognized, `out_valid`, `is_mem`, `is_branch`, `is_store`, `taken` and `misaligned` are zero on the next edge, and `addr` and `ra_sel` keep their previous values.
- R9: `is_store` is set exactly for opcodes 0x2D and 0x2C. `is_mem` is set for all five memory opcodes. `is_branch` is set for all five branch opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| rb_val | input | 64 | Base register value for memory accesses |
| ra_val | input | 64 | Register tested by conditional branches |
| pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | A recognized instruction was accepted on the last edge |
| is_mem | output | 1 | Result is a load or store address |
| is_branch | output | 1 | Result is a branch target |
| is_store | output | 1 | Memory access is a store |
| taken | output | 1 | Branch is taken |
| misaligned | output | 1 | Quadword access off an 8-byte boundary |
| ra_sel | output | 5 | Register field instr[25:21] of the accepted instruction |
| addr | output | 64 | Effective address or branch target |

## Verification
The assertions assume that `rst` is held high for at least one edge before any instruction is presented. They also assume that `instr`, `rb_val`, `ra_val` and `pc` are stable around each rising edge. Their address checks hold only when `rb_val` belongs to the same cycle as `instr`. The stimulus meets these assumptions: it changes every input on the falling edge only, pairs each instruction word with its own operand values, and releases reset only after two full cycles. Operand values are chosen to reach both carry wrap at 64 bits and the sign boundaries of both offset fields.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD64   = 6'h29;
  localparam logic [OPC_W-1:0] OPC_LD64AF = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ST64   = 6'h2D;
  localparam logic [OPC_W-1:0] OPC_LD32   = 6'h28;
  localparam logic [OPC_W-1:0] OPC_ST32   = 6'h2C;
  localparam logic [OPC_W-1:0] OPC_JMP    = 6'h30;
  localparam logic [OPC_W-1:0] OPC_BZ     = 6'h39;
  localparam logic [OPC_W-1:0] OPC_BNZ    = 6'h3D;
  localparam logic [OPC_W-1:0] OPC_BNEG   = 6'h3A;
  localparam logic [OPC_W-1:0] OPC_BNNEG  = 6'h3E;

  typedef enum logic [2:0] {
    TEST_ALWAYS,
    TEST_ZERO,
    TEST_NONZERO,
    TEST_NEG,
    TEST_NONNEG
  } test_e;

  typedef struct packed {
    logic  known;
    logic  mem;
    logic  store;
    logic  branch;
    logic  force_al;
    logic  quad;
    test_e test;
  } op_info_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import addr_gen_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_info_t         info
);

  always_comb begin
    info = '{known: 1'b0, mem: 1'b0, store: 1'b0, branch: 1'b0,
             force_al: 1'b0, quad: 1'b0, test: TEST_ALWAYS};
    case (opcode)
      OPC_LD64: begin
        info.known = 1'b1; info.mem = 1'b1; info.quad = 1'b1;
      end
      OPC_LD64AF: begin
        info.known = 1'b1; info.mem = 1'b1; info.quad = 1'b1;
        info.force_al = 1'b1;
      end
      OPC_ST64: begin
        info.known = 1'b1; info.mem = 1'b1; info.quad = 1'b1;
        info.store = 1'b1;
      end
      OPC_LD32: begin
        info.known = 1'b1; info.mem = 1'b1;
      end
      OPC_ST32: begin
        info.known = 1'b1; info.mem = 1'b1; info.store = 1'b1;
      end
      OPC_JMP: begin
        info.known = 1'b1; info.branch = 1'b1; info.test = TEST_ALWAYS;
      end
      OPC_BZ: begin
        info.known = 1'b1; info.branch = 1'b1; info.test = TEST_ZERO;
      end
      OPC_BNZ: begin
        info.known = 1'b1; info.branch = 1'b1; info.test = TEST_NONZERO;
      end
      OPC_BNEG: begin
        info.known = 1'b1; info.branch = 1'b1; info.test = TEST_NEG;
      end
      OPC_BNNEG: begin
        info.known = 1'b1; info.branch = 1'b1; info.test = TEST_NONNEG;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agu_cond.sv
module agu_cond
  import addr_gen_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  test_e             test,
  input  logic [DATA_W-1:0] value,
  output logic              hit
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (value == '0);
  assign is_neg  = value[DATA_W-1];

  always_comb begin
    case (test)
      TEST_ZERO:    hit = is_zero;
      TEST_NONZERO: hit = !is_zero;
      TEST_NEG:     hit = is_neg;
      TEST_NONNEG:  hit = !is_neg;
      default:      hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int ADDR_W     = 64,
  parameter int MDISP_W    = 16,
  parameter int BDISP_W    = 21,
  parameter int WORD_SHIFT = 2,
  parameter int CLR_BITS   = 3,
  parameter int STEP       = 4
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [MDISP_W-1:0] mdisp,
  input  logic [BDISP_W-1:0] bdisp,
  input  logic               sel_branch,
  input  logic               force_al,
  output logic [ADDR_W-1:0]  addr
);

  localparam int BOFF_W = BDISP_W + WORD_SHIFT;

  logic [ADDR_W-1:0] mem_off;
  logic [ADDR_W-1:0] br_off;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] sum;

  assign mem_off = {{(ADDR_W-MDISP_W){mdisp[MDISP_W-1]}}, mdisp};
  assign br_off  = {{(ADDR_W-BOFF_W){bdisp[BDISP_W-1]}}, bdisp, {WORD_SHIFT{1'b0}}};
  assign next_pc = pc + ADDR_W'(STEP);
  assign sum     = sel_branch ? (next_pc + br_off) : (base + mem_off);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < CLR_BITS) begin : g_clr
      assign addr[i] = sum[i] & ~force_al;
    end else begin : g_pass
      assign addr[i] = sum[i];
    end
  end

endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addr_gen_pkg::*;
#(
  parameter int INSN_W     = 32,
  parameter int ADDR_W     = 64,
  parameter int REG_IDX_W  = 5,
  parameter int MDISP_W    = 16,
  parameter int BDISP_W    = 21,
  parameter int WORD_SHIFT = 2,
  parameter int QUAD_BITS  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    instr,
  input  logic [ADDR_W-1:0]    rb_val,
  input  logic [ADDR_W-1:0]    ra_val,
  input  logic [ADDR_W-1:0]    pc,
  output logic                 out_valid,
  output logic                 is_mem,
  output logic                 is_branch,
  output logic                 is_store,
  output logic                 taken,
  output logic                 misaligned,
  output logic [REG_IDX_W-1:0] ra_sel,
  output logic [ADDR_W-1:0]    addr
);

  localparam int OPC_LSB  = INSN_W - OPC_W;
  localparam int RA_LSB   = OPC_LSB - REG_IDX_W;
  localparam int STEP     = INSN_W / 8;

  op_info_t          info;
  logic              cond_hit;
  logic              accept;
  logic [ADDR_W-1:0] addr_d;
  logic              mis_d;

  agu_decode u_decode (
    .opcode (instr[INSN_W-1:OPC_LSB]),
    .info   (info)
  );

  agu_cond #(.DATA_W(ADDR_W)) u_cond (
    .test  (info.test),
    .value (ra_val),
    .hit   (cond_hit)
  );

  agu_sum #(
    .ADDR_W    (ADDR_W),
    .MDISP_W   (MDISP_W),
    .BDISP_W   (BDISP_W),
    .WORD_SHIFT(WORD_SHIFT),
    .CLR_BITS  (QUAD_BITS),
    .STEP      (STEP)
  ) u_sum (
    .base      (rb_val),
    .pc        (pc),
    .mdisp     (instr[MDISP_W-1:0]),
    .bdisp     (instr[BDISP_W-1:0]),
    .sel_branch(info.branch),
    .force_al  (info.force_al),
    .addr      (addr_d)
  );

  assign accept = in_valid & info.known;
  assign mis_d  = info.quad & ~info.force_al & (|addr_d[QUAD_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      is_mem     <= 1'b0;
      is_branch  <= 1'b0;
      is_store   <= 1'b0;
      taken      <= 1'b0;
      misaligned <= 1'b0;
      ra_sel     <= '0;
      addr       <= '0;
    end else begin
      out_valid  <= accept;
      is_mem     <= accept & info.mem;
      is_branch  <= accept & info.branch;
      is_store   <= accept & info.store;
      taken      <= accept & info.branch & cond_hit;
      misaligned <= accept & mis_d;
      if (accept) begin
        ra_sel <= instr[RA_LSB +: REG_IDX_W];
        addr   <= addr_d;
      end
    end
  end

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk
  import addr_gen_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int MDISP_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [OPC_W-1:0]   opcode,
  input logic [MDISP_W-1:0] mdisp,
  input logic [ADDR_W-1:0]  rb_val,
  input logic               out_valid,
  input logic               is_mem,
  input logic               is_branch,
  input logic               is_store,
  input logic               taken,
  input logic               misaligned,
  input logic [ADDR_W-1:0]  addr
);

  logic              plain_mem;
  logic [ADDR_W-1:0] exp_mem;

  assign plain_mem = in_valid && (opcode == OPC_LD64 || opcode == OPC_ST64 ||
                                  opcode == OPC_LD32 || opcode == OPC_ST32);
  assign exp_mem   = rb_val + {{(ADDR_W-MDISP_W){mdisp[MDISP_W-1]}}, mdisp};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !is_mem && !is_branch && !taken && addr == '0)); // R1

  AST_MEM_SUM: assert property (@(posedge clk) disable iff (rst)
    plain_mem |=> (is_mem && addr == $past(exp_mem))); // R2

  AST_FORCED_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_LD64AF) |=> (is_mem && addr[2:0] == 3'b000 && !misaligned)); // R4

  AST_TAKEN_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
    taken |-> (is_branch && out_valid)); // R6

  AST_MISALIGN_QUAD: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (is_mem && addr[2:0] != 3'b000)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(addr))); // R8

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({is_mem, is_branch})); // R9

  AST_STORE_IS_MEM: assert property (@(posedge clk) disable iff (rst)
    is_store |-> is_mem); // R9

endmodule

bind addr_gen addr_gen_chk #(.ADDR_W(ADDR_W), .MDISP_W(MDISP_W)) u_addr_gen_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opcode    (instr[INSN_W-1:INSN_W-addr_gen_pkg::OPC_W]),
  .mdisp     (instr[MDISP_W-1:0]),
  .rb_val    (rb_val),
  .out_valid (out_valid),
  .is_mem    (is_mem),
  .is_branch (is_branch),
  .is_store  (is_store),
  .taken     (taken),
  .misaligned(misaligned),
  .addr      (addr)
);

// File: tb/test_addr_gen.sv
module test_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rb_val = '0;
  logic [63:0] ra_val = '0;
  logic [63:0] pc = '0;
  logic        out_valid, is_mem, is_branch, is_store, taken, misaligned;
  logic [4:0]  ra_sel;
  logic [63:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen i_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rb_val(rb_val), .ra_val(ra_val), .pc(pc),
    .out_valid(out_valid), .is_mem(is_mem), .is_branch(is_branch),
    .is_store(is_store), .taken(taken), .misaligned(misaligned),
    .ra_sel(ra_sel), .addr(addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mem(input logic [5:0] op, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [15:0] d);
    return {op, ra, rb, d};
  endfunction

  function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [4:0] ra,
                                        input logic [20:0] d);
    return {op, ra, d};
  endfunction

  function automatic logic [63:0] sx16(input logic [15:0] d);
    return {{48{d[15]}}, d};
  endfunction

  function automatic logic [63:0] br_tgt(input logic [63:0] p, input logic [20:0] d);
    return p + 64'd4 + {{41{d[20]}}, d, 2'b00};
  endfunction

  // present one instruction, wait for the edge, sample after it
  task automatic issue(input logic v, input logic [31:0] w, input logic [63:0] b,
                       input logic [63:0] a, input logic [63:0] p);
    @(negedge clk);
    in_valid = v; instr = w; rb_val = b; ra_val = a; pc = p;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    issue(1'b1, mk_mem(6'h29, 5'd3, 5'd4, 16'h0008), 64'h1000, 64'd0, 64'd0);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 addr", addr, 64'd0);
    chk("R1 flags", {58'd0, is_mem, is_branch, is_store, taken, misaligned, 1'b0}, 64'd0);
    chk("R1 ra_sel", {59'd0, ra_sel}, 64'd0);
  endtask

  task automatic t_mem();
    logic [63:0] b;
    logic [15:0] d;
    b = 64'h0000_0000_0001_0000; d = 16'h0010;
    issue(1'b1, mk_mem(6'h28, 5'd7, 5'd2, d), b, 64'd0, 64'd0);
    chk("R2 positive offset", addr, b + sx16(d));
    chk("R2 ra_sel", {59'd0, ra_sel}, 64'd7);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    d = 16'h8000;
    issue(1'b1, mk_mem(6'h29, 5'd1, 5'd2, d), b, 64'd0, 64'd0);
    chk("R2 most negative offset", addr, b + sx16(d));
    d = 16'hFFFC; b = 64'd0;
    issue(1'b1, mk_mem(6'h2C, 5'd31, 5'd9, d), b, 64'd0, 64'd0);
    chk("R2 wrap below zero", addr, 64'hFFFF_FFFF_FFFF_FFFC);
    d = 16'h7FFF; b = 64'hFFFF_FFFF_FFFF_FFF0;
    issue(1'b1, mk_mem(6'h28, 5'd5, 5'd9, d), b, 64'd0, 64'd0);
    chk("R2 carry wrap", addr, b + sx16(d));
    chk("R6 memory not taken", {63'd0, taken}, 64'd0);
  endtask

  task automatic t_forced_align();
    logic [63:0] b;
    b = 64'h0000_0000_0000_2005;
    issue(1'b1, mk_mem(6'h0B, 5'd2, 5'd3, 16'h0003), b, 64'd0, 64'd0);
    chk("R4 low bits cleared", addr, (b + 64'd3) & ~64'd7);
    chk("R7 forced-align not flagged", {63'd0, misaligned}, 64'd0);
    issue(1'b1, mk_mem(6'h0B, 5'd2, 5'd3, 16'hFFFF), 64'd0, 64'd0, 64'd0);
    chk("R4 negative forced-align", addr, 64'hFFFF_FFFF_FFFF_FFF8);
  endtask

  task automatic t_branch();
    logic [63:0] p;
    logic [20:0] d;
    p = 64'h0000_0001_0000_0100; d = 21'h000010;
    issue(1'b1, mk_br(6'h30, 5'd0, d), 64'hDEAD, 64'd0, p);
    chk("R3 forward target", addr, br_tgt(p, d));
    chk("R6 unconditional taken", {63'd0, taken}, 64'd1);
    chk("R9 branch class", {62'd0, is_branch, is_mem}, 64'd2);
    d = 21'h100000;
    issue(1'b1, mk_br(6'h30, 5'd0, d), 64'd0, 64'd0, p);
    chk("R3 most negative offset", addr, br_tgt(p, d));
    d = 21'h1FFFFF;
    issue(1'b1, mk_br(6'h39, 5'd0, d), 64'd0, 64'd0, 64'd0);
    chk("R3 self loop", addr, 64'd0);
    p = 64'hFFFF_FFFF_FFFF_FFFC; d = 21'h000001;
    issue(1'b1, mk_br(6'h30, 5'd0, d), 64'd0, 64'd0, p);
    chk("R3 wrap at 64 bits", addr, 64'd4);
  endtask

  task automatic t_cond();
    logic [5:0]  ops  [4] = '{6'h39, 6'h3D, 6'h3A, 6'h3E};
    logic [63:0] vals [3] = '{64'd0, 64'd5, 64'h8000_0000_0000_0000};
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 3; j++) begin
        logic e;
        case (i)
          0: e = (vals[j] == 0);
          1: e = (vals[j] != 0);
          2: e = vals[j][63];
          default: e = !vals[j][63];
        endcase
        issue(1'b1, mk_br(ops[i], 5'd4, 21'h8), 64'd0, vals[j], 64'h40);
        chk($sformatf("R5 op %h ra %h", ops[i], vals[j]), {63'd0, taken}, {63'd0, e});
      end
    end
  endtask

  task automatic t_misalign();
    issue(1'b1, mk_mem(6'h29, 5'd1, 5'd1, 16'h0004), 64'h100, 64'd0, 64'd0);
    chk("R7 quad load off boundary", {63'd0, misaligned}, 64'd1);
    issue(1'b1, mk_mem(6'h2D, 5'd1, 5'd1, 16'h0001), 64'h100, 64'd0, 64'd0);
    chk("R7 quad store off boundary", {63'd0, misaligned}, 64'd1);
    issue(1'b1, mk_mem(6'h29, 5'd1, 5'd1, 16'hFFF8), 64'h100, 64'd0, 64'd0);
    chk("R7 quad aligned", {63'd0, misaligned}, 64'd0);
    issue(1'b1, mk_mem(6'h28, 5'd1, 5'd1, 16'h0003), 64'h100, 64'd0, 64'd0);
    chk("R7 32-bit not flagged", {63'd0, misaligned}, 64'd0);
    issue(1'b1, mk_br(6'h30, 5'd1, 21'h0), 64'd0, 64'd0, 64'h2);
    chk("R7 branch not flagged", {63'd0, misaligned}, 64'd0);
  endtask

  task automatic t_idle();
    logic [63:0] hold;
    issue(1'b1, mk_mem(6'h28, 5'd9, 5'd1, 16'h0020), 64'h500, 64'd0, 64'd0);
    hold = addr;
    chk("R8 setup", hold, 64'h520);
    issue(1'b0, mk_mem(6'h2D, 5'd3, 5'd1, 16'h0001), 64'h900, 64'd0, 64'd0);
    chk("R8 idle valid low", {63'd0, out_valid}, 64'd0);
    chk("R8 idle flags", {59'd0, is_mem, is_branch, is_store, taken, misaligned}, 64'd0);
    chk("R8 idle addr held", addr, hold);
    chk("R8 idle ra_sel held", {59'd0, ra_sel}, 64'd9);
    issue(1'b1, {6'h3F, 26'h3FFFFFF}, 64'h900, 64'd0, 64'd0);
    chk("R8 unknown op valid low", {63'd0, out_valid}, 64'd0);
    chk("R8 unknown op flags", {59'd0, is_mem, is_branch, is_store, taken, misaligned}, 64'd0);
    chk("R8 unknown op addr held", addr, hold);
  endtask

  task automatic t_store();
    logic [5:0] ops [5] = '{6'h29, 6'h0B, 6'h2D, 6'h28, 6'h2C};
    for (int i = 0; i < 5; i++) begin
      logic st;
      st = (ops[i] == 6'h2D) || (ops[i] == 6'h2C);
      issue(1'b1, mk_mem(ops[i], 5'd1, 5'd1, 16'h0), 64'h800, 64'd0, 64'd0);
      chk($sformatf("R9 store flag op %h", ops[i]), {63'd0, is_store}, {63'd0, st});
      chk($sformatf("R9 mem class op %h", ops[i]), {62'd0, is_mem, is_branch}, 64'd2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_mem();
    t_forced_align();
    t_branch();
    t_cond();
    t_misalign();
    t_idle();
    t_store();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule